// File: doc/BRIEF.md
# Reservation Station Bank

This block is a small group of waiting slots placed in front of one shared arithmetic unit. An issued instruction lands in a free slot. Each slot then acts as a virtual copy of the unit. Each source operand is held in one of two forms: as a value, or as the nonzero tag of the station that will later produce it. A slot that still lacks an operand watches the result broadcast bus. When the broadcast tag matches one of its pending tags, it copies the data.

Once both operands are present, the slot competes for the single physical unit. The lowest-numbered ready slot wins, and at most one slot is sent per cycle. A slot stays occupied until its own result appears on the broadcast bus under its own station tag. It can take a new instruction from the following cycle.

Sizing is by parameter. The default is three slots for an adder. Two slots suit a multiplier.

Top module: `rs_bank`

## Requirements
- R1: After reset every slot is empty: `iss_ready` is 1 and `disp_valid` is 0.
- R2: An issue is taken on a cycle with `iss_valid` and `iss_ready` both high. `iss_ready` is 0 exactly when all slots are occupied. An issue offered while `iss_ready` is 0 has no effect and is never dispatched.
- R3: A taken issue goes to the lowest-index free slot. Slot i has station tag BASE_TAG+i, which is 1, 2, 3 by default. Tag 0 means "no producer".
- R4: A source tag of 0 means the matching value input is the operand. A nonzero tag is replaced by the broadcast data on the first cycle that `cdb_valid` is high with `cdb_tag` equal to it. After that the tag reads as 0.
- R5: Every slot waiting on the same tag captures the same broadcast in the same cycle.
- R6: A slot is eligible for dispatch only when both of its tags are 0. It becomes eligible on the cycle after the capture that cleared its last tag.
- R7: `disp_valid` is high only when `unit_free` is high. It presents the lowest-index eligible slot, with `disp_tag` set to that slot's station tag. Each slot is dispatched once.
- R8: If an issue coincides with a broadcast whose tag equals one of the issued source tags, the slot stores the broadcast data for that operand and does not wait.
- R9: A broadcast carrying a slot's own station tag frees that slot. `iss_ready` reflects the free slot one cycle later, and a new issue may then reuse it.
- R10: `disp_op`, `disp_a` and `disp_b` carry the issued operation code and the final j and k operands. The operation codes are 0 for add and 1 for subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued instruction |
| iss_vj | input | DATA_W | j operand value (used when iss_qj is 0) |
| iss_qj | input | TAG_W | j producer tag, 0 when the value is present |
| iss_vk | input | DATA_W | k operand value (used when iss_qk is 0) |
| iss_qk | input | TAG_W | k producer tag, 0 when the value is present |
| iss_ready | output | 1 | At least one slot is free |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Station tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| unit_free | input | 1 | The arithmetic unit accepts an operation this cycle |
| disp_valid | output | 1 | An operation is sent to the unit |
| disp_tag | output | TAG_W | Station tag of the dispatched slot |
| disp_op | output | OP_W | Operation code sent to the unit |
| disp_a | output | DATA_W | First operand sent to the unit |
| disp_b | output | DATA_W | Second operand sent to the unit |

## Verification
Directed sequences cover several situations:
- They fill the bank with a mix of slots: slots with values present, slots waiting on a foreign tag, and one slot waiting twice on the same tag. This separates correct readiness gating from dispatch that ignores tags, and it separates a shared capture from a capture of only one operand.
- With the unit held busy, a filled bank shows whether dispatch honours `unit_free`. An issue offered while full checks that it is ignored.
- A broadcast that coincides with an issue separates a correct bypass from a slot that waits forever on a stale tag.
- Randomized runs push three dependent instructions through the bank with a randomly stalling unit. Each run has random values and a random add or subtract. The final values must match a program-order model, which exposes wrong operand routing, lost captures and wrong slot reuse.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_OP_W = 2;
  typedef logic [RS_OP_W-1:0] rs_op_t;
  localparam rs_op_t RS_OP_ADD = rs_op_t'(0);
  localparam rs_op_t RS_OP_SUB = rs_op_t'(1);
endpackage

// File: rtl/rs_pick.sv
// Fixed-priority picker: lowest set request wins.
module rs_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pick
      if (i == 0) begin : g_first
        assign gnt[i] = req[i];
      end else begin : g_rest
        assign gnt[i] = req[i] & ~(|req[i-1:0]);
      end
    end
  endgenerate
  assign any = |req;
endmodule

// File: rtl/rs_slot.sv
// One waiting slot: holds an operation and two operands as value or tag.
module rs_slot #(
  parameter int                DATA_W = 32,
  parameter int                TAG_W  = 3,
  parameter int                OP_W   = 2,
  parameter logic [TAG_W-1:0]  MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              grant,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  logic              busy_q, busy_d;
  logic              sent_q, sent_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [DATA_W-1:0] vj_q, vj_d, vk_q, vk_d;
  logic [TAG_W-1:0]  qj_q, qj_d, qk_q, qk_d;
  logic              en;
  logic              hit_iss_j, hit_iss_k, hit_j, hit_k, hit_own;

  assign hit_iss_j = cdb_valid && (iss_qj != '0) && (cdb_tag == iss_qj);
  assign hit_iss_k = cdb_valid && (iss_qk != '0) && (cdb_tag == iss_qk);
  assign hit_j     = cdb_valid && (qj_q != '0) && (cdb_tag == qj_q);
  assign hit_k     = cdb_valid && (qk_q != '0) && (cdb_tag == qk_q);
  assign hit_own   = cdb_valid && (cdb_tag == MY_TAG);
  assign en        = alloc | busy_q;

  always_comb begin
    busy_d = busy_q;
    sent_d = sent_q;
    op_d   = op_q;
    vj_d   = vj_q;
    vk_d   = vk_q;
    qj_d   = qj_q;
    qk_d   = qk_q;
    if (alloc) begin
      busy_d = 1'b1;
      sent_d = 1'b0;
      op_d   = iss_op;
      vj_d   = hit_iss_j ? cdb_data : iss_vj;
      qj_d   = hit_iss_j ? '0 : iss_qj;
      vk_d   = hit_iss_k ? cdb_data : iss_vk;
      qk_d   = hit_iss_k ? '0 : iss_qk;
    end else if (busy_q) begin
      if (hit_own) begin
        busy_d = 1'b0;
        sent_d = 1'b0;
        qj_d   = '0;
        qk_d   = '0;
      end else begin
        if (hit_j) begin
          vj_d = cdb_data;
          qj_d = '0;
        end
        if (hit_k) begin
          vk_d = cdb_data;
          qk_d = '0;
        end
        if (grant) sent_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      qj_q   <= '0;
      qk_q   <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      sent_q <= sent_d;
      qj_q   <= qj_d;
      qk_q   <= qk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      op_q <= op_d;
      vj_q <= vj_d;
      vk_q <= vk_d;
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q && !sent_q && (qj_q == '0) && (qk_q == '0);
  assign op    = op_q;
  assign vj    = vj_q;
  assign vk    = vk_q;

  assert_capture_j_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !alloc && hit_j && !hit_own) |=> (qj_q == '0 && vj_q == $past(cdb_data)));
  assert_capture_k_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !alloc && hit_k && !hit_own) |=> (qk_q == '0 && vk_q == $past(cdb_data)));
  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && hit_iss_j) |=> (qj_q == '0 && vj_q == $past(cdb_data)));
  assert_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !alloc && hit_own) |=> !busy_q);
  assert_grant_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (busy_q && qj_q == '0 && qk_q == '0));
  assert_alloc_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy_q);
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  parameter int OP_W     = rs_pkg::RS_OP_W,
  parameter int N_SLOT   = 3,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  output logic              iss_ready,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              unit_free,
  output logic              disp_valid,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b
);
  localparam int LAST_TAG = BASE_TAG + N_SLOT - 1;

  logic [N_SLOT-1:0] busy_vec, free_vec, free_pick, alloc_vec;
  logic [N_SLOT-1:0] ready_vec, ready_pick, grant_vec;
  logic              any_free, any_ready;
  logic [OP_W-1:0]   op_arr [N_SLOT];
  logic [DATA_W-1:0] vj_arr [N_SLOT];
  logic [DATA_W-1:0] vk_arr [N_SLOT];

  assign free_vec  = ~busy_vec;
  assign alloc_vec = free_pick & {N_SLOT{iss_valid}};
  assign iss_ready = any_free;
  assign grant_vec = ready_pick & {N_SLOT{unit_free}};
  assign disp_valid = any_ready & unit_free;

  rs_pick #(.N(N_SLOT)) u_alloc_pick (.req(free_vec),  .gnt(free_pick),  .any(any_free));
  rs_pick #(.N(N_SLOT)) u_disp_pick  (.req(ready_vec), .gnt(ready_pick), .any(any_ready));

  genvar i;
  generate
    for (i = 0; i < N_SLOT; i++) begin : g_slot
      rs_slot #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
        .MY_TAG(TAG_W'(BASE_TAG + i))
      ) u_slot (
        .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[i]),
        .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
        .iss_vk(iss_vk), .iss_qk(iss_qk),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .grant(grant_vec[i]), .busy(busy_vec[i]), .ready(ready_vec[i]),
        .op(op_arr[i]), .vj(vj_arr[i]), .vk(vk_arr[i])
      );
    end
  endgenerate

  always_comb begin
    disp_tag = '0;
    disp_op  = '0;
    disp_a   = '0;
    disp_b   = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      if (ready_pick[s]) begin
        disp_tag = disp_tag | TAG_W'(BASE_TAG + s);
        disp_op  = disp_op  | op_arr[s];
        disp_a   = disp_a   | vj_arr[s];
        disp_b   = disp_b   | vk_arr[s];
      end
    end
  end

  assert_one_dispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  assert_unit_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> unit_free);
  assert_tag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (int'(disp_tag) >= BASE_TAG && int'(disp_tag) <= LAST_TAG));
  assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> ($countones(busy_vec) <= $countones($past(busy_vec))));
endmodule

// File: tb/tb_rs_bank.sv
module tb_rs_bank;
  localparam int DW = 32;
  localparam int TW = 3;
  localparam int OW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid;
  logic [OW-1:0] iss_op;
  logic [DW-1:0] iss_vj, iss_vk;
  logic [TW-1:0] iss_qj, iss_qk;
  logic iss_ready;
  logic cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_data;
  logic unit_free;
  logic disp_valid;
  logic [TW-1:0] disp_tag;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b;

  rs_bank dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
    .iss_vk(iss_vk), .iss_qk(iss_qk), .iss_ready(iss_ready),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .unit_free(unit_free), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench-side model state
  logic          auto_mode = 1'b0;
  logic          m_cdb_v = 1'b0;
  logic [TW-1:0] m_cdb_tag = '0;
  logic [DW-1:0] m_cdb_data = '0;
  logic          m_free = 1'b0;
  logic          pend_v = 1'b0;
  logic [TW-1:0] pend_tag = '0;
  logic [DW-1:0] pend_d = '0;
  logic [2:0]    mbusy = '0;
  logic [TW-1:0] rstat [3];
  logic [DW-1:0] rval [3];
  logic          o_dv, o_rdy, accepted;
  logic [TW-1:0] o_tag, acc_tag;
  logic [OW-1:0] o_op;
  logic [DW-1:0] o_a, o_b;

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] alu(input logic [OW-1:0] op,
                                        input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (op == OW'(1)) ? a - b : a + b;
  endfunction

  // One cycle: inputs are set, outputs sampled 1 ns later, then the edge.
  task automatic tick();
    int idx;
    if (auto_mode) begin
      cdb_valid = pend_v; cdb_tag = pend_tag; cdb_data = pend_d;
      unit_free = ($urandom % 4) != 0;
    end else begin
      cdb_valid = m_cdb_v; cdb_tag = m_cdb_tag; cdb_data = m_cdb_data;
      unit_free = m_free;
    end
    #1;
    o_dv = disp_valid; o_rdy = iss_ready; o_tag = disp_tag;
    o_op = disp_op; o_a = disp_a; o_b = disp_b;
    check(o_rdy == (mbusy != 3'b111), "R2 iss_ready vs occupancy", DW'(o_rdy),
          DW'(mbusy != 3'b111));
    check(!o_dv || unit_free, "R7 dispatch only when unit free", DW'(o_dv), 0);
    accepted = iss_valid && o_rdy;
    idx = 0;
    if (accepted) begin
      for (int s = 2; s >= 0; s--) if (!mbusy[s]) idx = s;
      acc_tag = TW'(idx + 1);
    end
    if (auto_mode) begin
      pend_v = 1'b0;
      if (o_dv) begin
        check(mbusy[o_tag - 1], "R7 dispatched slot occupied", DW'(o_tag), 0);
        pend_v = 1'b1; pend_tag = o_tag; pend_d = alu(o_op, o_a, o_b);
      end
    end
    if (cdb_valid) begin
      for (int r = 0; r < 3; r++)
        if (rstat[r] == cdb_tag && rstat[r] != '0) begin
          rval[r] = cdb_data; rstat[r] = '0;
        end
      if (cdb_tag >= 1 && cdb_tag <= 3) mbusy[cdb_tag - 1] = 1'b0;
    end
    if (accepted) mbusy[idx] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    iss_valid = 1'b0;
    m_cdb_v = 1'b0;
  endtask

  task automatic issue_now(input logic [OW-1:0] op, input logic [DW-1:0] vj,
                           input logic [TW-1:0] qj, input logic [DW-1:0] vk,
                           input logic [TW-1:0] qk);
    iss_valid = 1'b1; iss_op = op; iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
  endtask

  // Issue from model registers: a source index < 0 means immediate.
  task automatic issue_reg(input logic [OW-1:0] op, input int sj, input logic [DW-1:0] ij,
                           input int sk, input logic [DW-1:0] ik, input int dst);
    int tries = 0;
    do begin
      issue_now(op, (sj < 0) ? ij : rval[sj], (sj < 0) ? '0 : rstat[sj],
                    (sk < 0) ? ik : rval[sk], (sk < 0) ? '0 : rstat[sk]);
      tick();
      tries++;
    end while (!accepted && tries < 50);
    check(accepted, "R2 issue eventually accepted", DW'(accepted), 1);
    rstat[dst] = acc_tag;
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] a, b, c, e1, e2, e3;
    logic [OW-1:0] op2;
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < 3; r++) begin rstat[r] = '0; rval[r] = '0; end
    iss_valid = 0; iss_op = 0; iss_vj = 0; iss_vk = 0; iss_qj = 0; iss_qk = 0;
    cdb_valid = 0; cdb_tag = 0; cdb_data = 0; unit_free = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    m_free = 1'b1; tick();
    check(o_rdy == 1'b1, "R1 ready after reset", DW'(o_rdy), 1);
    check(o_dv == 1'b0, "R1 no dispatch after reset", DW'(o_dv), 0);

    // Fill bank: A waits on 6 (k), B waits twice on 6, C ready
    m_free = 1'b0;
    issue_now(OW'(0), 5, '0, 0, TW'(6));  tick();
    issue_now(OW'(1), 0, TW'(6), 0, TW'(6)); tick();
    issue_now(OW'(0), 7, '0, 8, '0);   tick();
    issue_now(OW'(0), 99, '0, 99, '0); tick();
    check(o_rdy == 1'b0, "R2 full bank stalls issue", DW'(o_rdy), 0);
    check(o_dv == 1'b0, "R7 no dispatch while unit busy", DW'(o_dv), 0);

    m_free = 1'b1; tick();
    check(o_dv && o_tag == 3, "R6 only ready slot dispatched", DW'(o_tag), 3);
    check(o_a == 7 && o_b == 8, "R10 operands of slot 3", o_a, 7);

    m_cdb_v = 1'b1; m_cdb_tag = TW'(6); m_cdb_data = 11; tick();
    check(o_dv == 1'b0, "R6 waiting slots not eligible", DW'(o_dv), 0);

    tick();
    check(o_dv && o_tag == 1, "R7 lowest ready slot first", DW'(o_tag), 1);
    check(o_a == 5 && o_b == 11, "R4 captured k operand", o_b, 11);
    check(o_op == OW'(0), "R10 op add", DW'(o_op), 0);
    tick();
    check(o_dv && o_tag == 2, "R5 second waiter dispatched", DW'(o_tag), 2);
    check(o_a == 11 && o_b == 11, "R5 both operands captured same cycle", o_a, 11);
    check(o_op == OW'(1), "R10 op sub", DW'(o_op), 1);
    tick();
    check(o_dv == 1'b0, "R2 stalled issue ignored, each slot once", DW'(o_dv), 0);

    m_cdb_v = 1'b1; m_cdb_tag = TW'(3); m_cdb_data = 15; tick();
    check(o_rdy == 1'b0, "R9 not free in broadcast cycle", DW'(o_rdy), 0);
    tick();
    check(o_rdy == 1'b1, "R9 free after own-tag broadcast", DW'(o_rdy), 1);

    // R8: issue waits on tag 1 while tag 1 broadcasts
    m_free = 1'b0;
    issue_now(OW'(0), 0, TW'(1), 1, '0);
    m_cdb_v = 1'b1; m_cdb_tag = TW'(1); m_cdb_data = 42; tick();
    m_free = 1'b1; tick();
    check(o_dv && o_tag == 3, "R9 freed slot reused", DW'(o_tag), 3);
    check(o_a == 42 && o_b == 1, "R8 bypass on same-cycle issue", o_a, 42);
    m_free = 1'b0;
    m_cdb_v = 1'b1; m_cdb_tag = TW'(2); m_cdb_data = 0; tick();
    m_cdb_v = 1'b1; m_cdb_tag = TW'(3); m_cdb_data = 0; tick();
    tick();
    check(o_rdy == 1'b1 && o_dv == 1'b0, "R9 bank drained", DW'(o_rdy), 1);

    // Random dependent chains against a program-order model (R3 R4 R8 R10)
    auto_mode = 1'b1;
    for (int it = 0; it < 40; it++) begin
      a = $urandom; b = $urandom; c = $urandom;
      op2 = OW'($urandom % 2);
      e1 = a + b; e2 = alu(op2, e1, c); e3 = e2 + e1;
      issue_reg(OW'(0), -1, a, -1, b, 0);
      issue_reg(op2, 0, 0, -1, c, 1);
      issue_reg(OW'(0), 1, 0, 0, 0, 2);
      for (int w = 0; w < 200 && (rstat[2] != '0 || pend_v); w++) tick();
      check(rval[0] == e1, "R4 chain first result", rval[0], e1);
      check(rval[1] == e2, "R10 chain second result", rval[1], e2);
      check(rval[2] == e3, "R8 chain third result", rval[2], e3);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule